// File: doc/BRIEF.md
# Glitch-Free Clock Stop Control

This block sits between a clock synthesizer and the output pins of a clock generator. It takes two generated clock waveforms, one for a bank of PCI-rate outputs and one for a set of differential CPU pairs, and passes them through per-output gates. A gate closes or opens only at a point in the waveform where doing so cannot shorten a pulse. The PCI bank stops on a request from either an active-low pin or a software run bit. The CPU pairs stop on a separate active-low pin, but only after the request has been seen on two consecutive CPU clock rising edges.

Each single-ended output parks low when it is stopped. Each CPU pair parks with the true leg high and the complement leg undriven. The block reports the drive state of the complement leg so the analog pad can release it. Per-output bits select which outputs are enabled and which outputs obey a stop request. All logic runs on a sampling clock that is fast compared with the generated clocks, and the generated clocks arrive as level inputs.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While reset is held, every single-ended output is low and every CPU pair is parked (true 1, complement 0, complement drive 0).
- R2: With the PCI stop pin low, every enabled PCI output stays low after it finishes its current high phase. CPU pairs keep toggling.
- R3: Clearing the software run bit (0 = stop) stops the PCI outputs in the same way as the pin. The effective request is the OR of the two sources.
- R4: Each free-running PCI output has a stoppable bit. At 0 the output keeps toggling during a PCI stop. At 1 it stops low with the other PCI outputs.
- R5: A single-ended output whose enable bit (1 = on) is 0 stays low whatever the stop inputs are.
- R6: A single-ended output rises only after its source was high and falls only after its source was low, so every high pulse has the full source width.
- R7: With the CPU stop pin low, each non-exempt pair parks: true held high, complement low and undriven (complement drive 0). A running pair has complement drive 1 and legs of opposite value.
- R8: A pair whose free-running bit (1 = exempt) is set keeps toggling during a CPU stop.
- R9: A pair whose enable bit is 0 parks in the same state as a stopped pair.
- R10: A CPU pair enters or leaves the parked state only while its source is high, and its true leg falls only after the source was low. No low phase of the true leg is ever shortened.
- R11: A CPU stop request takes effect only after it is seen on two consecutive CPU source rising edges. A request shorter than one CPU period never parks a pair.
- R12: When a stop request or a disable is withdrawn, the output resumes toggling, starting with a full-width pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pci_src | input | 1 | Generated PCI-rate clock waveform |
| cpu_src | input | 1 | Generated CPU-rate clock waveform |
| pci_stop_n | input | 1 | PCI stop pin, active low, asynchronous |
| cpu_stop_n | input | 1 | CPU stop pin, active low, asynchronous |
| sw_pci_run | input | 1 | Software PCI run bit, 0 requests stop |
| pci_en | input | NPCI | Enable per PCI output |
| pcif_en | input | NPCIF | Enable per free-running PCI output |
| pcif_stoppable | input | NPCIF | 1 makes a free-running PCI output obey PCI stop |
| cpu_en | input | NCPU | Enable per CPU pair |
| cpu_free | input | NCPU | 1 exempts a CPU pair from CPU stop |
| pci_clk | output | NPCI | Gated PCI outputs |
| pcif_clk | output | NPCIF | Gated free-running PCI outputs |
| cpu_t | output | NCPU | True leg of each CPU pair |
| cpu_c | output | NCPU | Complement leg of each CPU pair |
| cpu_c_drv | output | NCPU | 1 when the complement leg is driven |

## Verification
A gate register that updates in the wrong phase of its source shows up at the ports as a clipped pulse. On a PCI output this is a high run shorter than the source high width. On a CPU true leg it is a low run shorter than the source low width. Either shows up within one source period of the request edge. A stuck or wrongly merged stop state appears as an output that keeps toggling or stays flat across a whole observation window, within about three source periods of the input change. A CPU qualifier that counts too few edges parks a pair on a short request pulse, and this is visible on the complement drive flag.

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl #(
  parameter int NPCI        = 7,
  parameter int NPCIF       = 3,
  parameter int NCPU        = 3,
  parameter int CPU_QUAL    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pci_src,
  input  logic             cpu_src,
  input  logic             pci_stop_n,
  input  logic             cpu_stop_n,
  input  logic             sw_pci_run,
  input  logic [NPCI-1:0]  pci_en,
  input  logic [NPCIF-1:0] pcif_en,
  input  logic [NPCIF-1:0] pcif_stoppable,
  input  logic [NCPU-1:0]  cpu_en,
  input  logic [NCPU-1:0]  cpu_free,
  output logic [NPCI-1:0]  pci_clk,
  output logic [NPCIF-1:0] pcif_clk,
  output logic [NCPU-1:0]  cpu_t,
  output logic [NCPU-1:0]  cpu_c,
  output logic [NCPU-1:0]  cpu_c_drv
);
  localparam int QW = $clog2(CPU_QUAL + 1);
  localparam logic [QW-1:0] QMAX = QW'(CPU_QUAL);

  logic [SYNC_STAGES-1:0] pci_sync, cpu_sync;
  logic pci_src_q, cpu_src_q, pci_halt;
  logic [QW-1:0] cpu_cnt;
  logic [NPCI-1:0]  pci_run, pci_run_nx, pci_want;
  logic [NPCIF-1:0] pcif_run, pcif_run_nx, pcif_want;
  logic [NCPU-1:0]  cpu_run, cpu_run_nx, cpu_want;

  wire pci_req  = !pci_sync[SYNC_STAGES-1] || !sw_pci_run;
  wire cpu_req  = !cpu_sync[SYNC_STAGES-1];
  wire pci_rise = pci_src && !pci_src_q;
  wire cpu_rise = cpu_src && !cpu_src_q;
  wire cpu_halt = (cpu_cnt == QMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pci_sync  <= '1;
      cpu_sync  <= '1;
      pci_src_q <= 1'b0;
      cpu_src_q <= 1'b0;
      pci_halt  <= 1'b0;
      cpu_cnt   <= '0;
    end else begin
      pci_sync  <= {pci_sync[SYNC_STAGES-2:0], pci_stop_n};
      cpu_sync  <= {cpu_sync[SYNC_STAGES-2:0], cpu_stop_n};
      pci_src_q <= pci_src;
      cpu_src_q <= cpu_src;
      if (pci_rise) pci_halt <= pci_req;
      if (cpu_rise) begin
        if (!cpu_req)             cpu_cnt <= '0;
        else if (cpu_cnt != QMAX) cpu_cnt <= cpu_cnt + 1'b1;
      end
    end
  end

  assign pci_want  = pci_en & {NPCI{!pci_halt}};
  assign pcif_want = pcif_en & ~(pcif_stoppable & {NPCIF{pci_halt}});
  assign cpu_want  = cpu_en & ~(~cpu_free & {NCPU{cpu_halt}});

  // single-ended gates move while the source is low, pair gates while it is high
  assign pci_run_nx  = pci_src ? pci_run  : pci_want;
  assign pcif_run_nx = pci_src ? pcif_run : pcif_want;
  assign cpu_run_nx  = cpu_src ? cpu_want : cpu_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pci_run   <= '0;
      pcif_run  <= '0;
      cpu_run   <= '0;
      pci_clk   <= '0;
      pcif_clk  <= '0;
      cpu_t     <= '1;
      cpu_c     <= '0;
      cpu_c_drv <= '0;
    end else begin
      pci_run   <= pci_run_nx;
      pcif_run  <= pcif_run_nx;
      cpu_run   <= cpu_run_nx;
      pci_clk   <= {NPCI{pci_src}} & pci_run_nx;
      pcif_clk  <= {NPCIF{pci_src}} & pcif_run_nx;
      cpu_t     <= {NCPU{cpu_src}} | ~cpu_run_nx;
      cpu_c     <= {NCPU{!cpu_src}} & cpu_run_nx;
      cpu_c_drv <= cpu_run_nx;
    end
  end
endmodule

// File: rtl/clk_stop_ctrl_chk.sv
module clk_stop_ctrl_chk #(
  parameter int NPCI  = 7,
  parameter int NPCIF = 3,
  parameter int NCPU  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pci_src,
  input logic             cpu_src,
  input logic [NPCI-1:0]  pci_clk,
  input logic [NPCIF-1:0] pcif_clk,
  input logic [NCPU-1:0]  cpu_t,
  input logic [NCPU-1:0]  cpu_c,
  input logic [NCPU-1:0]  cpu_c_drv
);
  for (genvar i = 0; i < NPCI; i++) begin : g_pci
    AST_PCI_RISE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pci_clk[i]) |-> $past(pci_src)); // R6
    AST_PCI_FALL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pci_clk[i]) |-> !$past(pci_src)); // R6
  end
  for (genvar i = 0; i < NPCIF; i++) begin : g_pcif
    AST_PCIF_RISE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pcif_clk[i]) |-> $past(pci_src)); // R6
    AST_PCIF_FALL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pcif_clk[i]) |-> !$past(pci_src)); // R6
  end
  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    AST_CPU_PARK_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_c_drv[i] |-> (cpu_t[i] && !cpu_c[i])); // R7
    AST_CPU_RUN_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_c_drv[i] |-> (cpu_t[i] != cpu_c[i])); // R7
    AST_CPU_PARK_AT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cpu_c_drv[i]) |-> ($past(cpu_src) && cpu_t[i])); // R10
    AST_CPU_TRUE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_t[i]) |-> !$past(cpu_src)); // R10
  end
endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(.NPCI(NPCI), .NPCIF(NPCIF), .NCPU(NCPU)) u_chk (.*);

// File: tb/clk_stop_ctrl_test.sv
module clk_stop_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [2:0] ph = '0;
  always @(negedge clk) ph <= ph + 1'b1;
  wire pci_src = ph[2];
  wire cpu_src = ph[1];

  logic pci_stop_n = 1'b1, cpu_stop_n = 1'b1, sw_pci_run = 1'b1;
  logic [6:0] pci_en = '1;
  logic [2:0] pcif_en = '1, pcif_stoppable = '0, cpu_en = '1, cpu_free = '0;
  wire [6:0] pci_clk;
  wire [2:0] pcif_clk, cpu_t, cpu_c, cpu_c_drv;

  clk_stop_ctrl uut (.clk, .rst_n, .pci_src, .cpu_src, .pci_stop_n, .cpu_stop_n,
    .sw_pci_run, .pci_en, .pcif_en, .pcif_stoppable, .cpu_en, .cpu_free,
    .pci_clk, .pcif_clk, .cpu_t, .cpu_c, .cpu_c_drv);

  // observation vector: pci 0-6, pcif 7-9, cpu_t 10-12, cpu_c_drv 13-15
  wire [15:0] mon = {cpu_c_drv, cpu_t, pcif_clk, pci_clk};

  int checks = 0, fails = 0;
  int runt_pci = 0, runt_pcif = 0, runt_cpu = 0;
  int hl_pci = 0, hl_pcif = 0, ll_cpu = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  typedef struct { int idx; int kind; string tag; } item_t;
  item_t q[$];
  bit busy = 1'b0;

  task automatic expect_on(input int idx, input int kind, input string tag);
    item_t it;
    it.idx = idx; it.kind = kind; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic drain();
    #1;
    wait (q.size() == 0 && !busy);
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  // monitor: kind 0 = stays low, 1 = stays high, 2 = toggles
  initial forever begin
    item_t it;
    bit s0, s1;
    int got;
    wait (q.size() > 0);
    busy = 1'b1;
    it = q.pop_front();
    s0 = 1'b0; s1 = 1'b0;
    repeat (32) begin
      @(negedge clk);
      if (mon[it.idx]) s1 = 1'b1; else s0 = 1'b1;
    end
    got = (s0 && s1) ? 2 : (s1 ? 1 : 0);
    chk(got == it.kind, it.tag, $sformatf("output bit %0d behaviour", it.idx), got, it.kind);
    busy = 1'b0;
  end

  // pulse width monitors for R6 and R10
  always @(negedge clk) if (rst_n) begin
    if (pci_clk[0]) hl_pci++;
    else begin if (hl_pci != 0 && hl_pci != 4) runt_pci++; hl_pci = 0; end
    if (pcif_clk[0]) hl_pcif++;
    else begin if (hl_pcif != 0 && hl_pcif != 4) runt_pcif++; hl_pcif = 0; end
    if (!cpu_t[0]) ll_cpu++;
    else begin if (ll_cpu != 0 && ll_cpu != 2) runt_cpu++; ll_cpu = 0; end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(pci_clk == 0 && pcif_clk == 0, "R1", "single-ended in reset", {pcif_clk, pci_clk}, 0);
    chk(cpu_t == 3'b111 && cpu_c == 0 && cpu_c_drv == 0, "R1", "pairs in reset",
        {cpu_t, cpu_c, cpu_c_drv}, 9'b111000000);
    rst_n = 1'b1;

    settle();
    expect_on(3, 2, "R12"); expect_on(8, 2, "R12"); expect_on(12, 2, "R12"); expect_on(13, 1, "R12");
    drain();

    pci_stop_n = 1'b0; pcif_stoppable = 3'b010;
    settle();
    expect_on(0, 0, "R2"); expect_on(6, 0, "R2"); expect_on(8, 0, "R4");
    expect_on(7, 2, "R4"); expect_on(10, 2, "R2");
    drain();

    pci_stop_n = 1'b1;
    settle();
    expect_on(0, 2, "R12"); expect_on(8, 2, "R12");
    drain();

    sw_pci_run = 1'b0;
    settle();
    expect_on(2, 0, "R3"); expect_on(8, 0, "R3"); expect_on(7, 2, "R4");
    drain();

    sw_pci_run = 1'b1; pci_en[4] = 1'b0; pcif_en[2] = 1'b0;
    settle();
    expect_on(4, 0, "R5"); expect_on(5, 2, "R5"); expect_on(9, 0, "R5");
    drain();

    cpu_stop_n = 1'b0; cpu_free = 3'b100;
    settle();
    expect_on(10, 1, "R7"); expect_on(13, 0, "R7"); expect_on(12, 2, "R8");
    expect_on(15, 1, "R8"); expect_on(0, 2, "R7");
    drain();

    cpu_stop_n = 1'b1; cpu_en[1] = 1'b0;
    settle();
    expect_on(11, 1, "R9"); expect_on(14, 0, "R9"); expect_on(10, 2, "R12"); expect_on(13, 1, "R12");
    drain();

    expect_on(13, 1, "R11");
    repeat (6) @(negedge clk);
    cpu_stop_n = 1'b0;
    repeat (3) @(negedge clk);
    cpu_stop_n = 1'b1;
    drain();

    chk(runt_pci == 0, "R6", "clipped pci pulses", runt_pci, 0);
    chk(runt_pcif == 0, "R6", "clipped pcif pulses", runt_pcif, 0);
    chk(runt_cpu == 0, "R10", "clipped cpu low phases", runt_cpu, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule